// File: doc/BRIEF.md
# Page-Splitting Flash Write Sequencer

This block turns one write request (a 24-bit start offset, a byte count and a stream of data bytes) into the command sequence that programs a serial NOR flash. The flash accepts program data only within one page, so the request is cut into chunks that never cross a page edge. The first chunk runs from the start offset up to the end of its page. Full pages follow, and a shorter tail ends the request. The page size is a runtime input and must be a power of two from 16 to 256.

For every chunk the sequencer first reads the flash status until the busy bit is clear, leaving at least one idle cycle between reads. It then issues write-enable and checks that the engine reports the bank's write-mode flag. Only then does it issue the page-program command. Commands go to a separate command engine through a request/acknowledge port. The engine then signals completion. During a program command, the engine's byte pulls reach the data source. Finally the block reports done, the number of bytes written and an error code. Page size, device size and both timeout budgets must be held steady while a request runs.

Top module: `flash_page_writer`

## Requirements
- R1: The first program chunk has length min(page_size - (start & (page_size-1)), count).
- R2: Every later chunk starts at a page boundary and has length min(page_size, bytes remaining).
- R3: Before each chunk a status read (cmd_hdr opcode 0x05, cmd_len 0) is repeated while cmd_wip is 1, with cmd_req low for at least one cycle after each busy answer.
- R4: Once the flash is ready, write-enable (opcode 0x06, cmd_len 0) is issued. If cmd_wm is 0 at its completion, the request ends with err 2 and that chunk is not programmed.
- R5: Page program is sent as cmd_hdr = {8'h02, address[23:16], address[15:8], address[7:0]} (most significant byte sent first) with cmd_len = chunk length. src_pop follows eng_pull only while a program command waits for completion.
- R6: A request with start + count > dev_size ends with done, err 1 and bytes_written 0, and no command is issued.
- R7: A zero-length request ends with done, err 0 and bytes_written 0, and no command is issued.
- R8: bytes_written grows only when a program command completes. After a failure it holds the total of the earlier chunks.
- R9: If the ready polling of one chunk lasts ready_tmo cycles or more without the busy bit clearing, the request ends with err 3.
- R10: If a command is not acknowledged, or does not complete, within cmd_tmo cycles, the request ends with err 2.
- R11: cmd_req stays high with cmd_hdr and cmd_len unchanged until cmd_ack.
- R12: req_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start pulse for a write request |
| req_addr | input | 24 | Start byte offset |
| req_len | input | 16 | Byte count |
| page_size | input | 9 | Page size in bytes, power of two 16..256 |
| dev_size | input | 25 | Device size in bytes |
| ready_tmo | input | 20 | Ready-poll budget per chunk, cycles |
| cmd_tmo | input | 20 | Per-command acknowledge/completion budget, cycles |
| cmd_req | output | 1 | Command request to the engine |
| cmd_hdr | output | 32 | Opcode and three address bytes, sent MSB first |
| cmd_len | output | 9 | Data bytes following the header |
| cmd_ack | input | 1 | Engine accepted the command |
| cmd_done | input | 1 | Engine finished the command |
| cmd_wip | input | 1 | Bit 0 of the returned status byte |
| cmd_wm | input | 1 | Write-mode flag of the bank after write-enable |
| eng_pull | input | 1 | Engine takes one data byte |
| src_pop | output | 1 | Pop strobe to the data source |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| bytes_written | output | 16 | Bytes in completed chunks |
| err | output | 2 | 0 ok, 1 range, 2 I/O, 3 busy timeout |

## Verification
Writes are tried with an unaligned start that yields a head, full pages and a tail, with an aligned full page, and with a short transfer inside one page. Other cases use page sizes of 16, 32, 64 and 256, so a wrong mask or a wrong min choice shows up as a misplaced header address or a wrong length. A scripted engine makes the busy bit stay set for several reads, withholds write-mode, drops a completion, or never acknowledges. These runs separate the I/O, busy and range error codes and show whether the reported byte total counts only finished chunks. A request offered mid-run and a request ending exactly at the device end check that the range and busy gating sit on the right side of each boundary.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int TW = 20,
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [PW-1:0] page_size,
  input  logic [AW:0]   dev_size,
  input  logic [TW-1:0] ready_tmo,
  input  logic [TW-1:0] cmd_tmo,
  output logic          cmd_req,
  output logic [AW+7:0] cmd_hdr,
  output logic [PW-1:0] cmd_len,
  input  logic          cmd_ack,
  input  logic          cmd_done,
  input  logic          cmd_wip,
  input  logic          cmd_wm,
  input  logic          eng_pull,
  output logic          src_pop,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] bytes_written,
  output logic [1:0]    err
);
  localparam logic [1:0] E_OK = 2'd0, E_RANGE = 2'd1, E_IO = 2'd2, E_BUSY = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_PREQ, S_PWAIT, S_PGAP, S_WREQ, S_WWAIT, S_GREQ, S_GWAIT} st_t;
  st_t state;

  logic [AW-1:0] addr;
  logic [LW-1:0] rem;
  logic [TW-1:0] tmr, rdy;
  logic [PW-1:0] room, chunk;
  logic          too_far, in_poll;

  assign room    = page_size - (addr[PW-1:0] & (page_size - 1'b1));
  assign chunk   = (LW'(room) < rem) ? room : rem[PW-1:0];
  assign too_far = ({1'b0, req_addr} + (AW+1)'(req_len)) > dev_size;
  assign in_poll = state inside {S_PREQ, S_PWAIT, S_PGAP};

  assign busy    = state != S_IDLE;
  assign cmd_req = state inside {S_PREQ, S_WREQ, S_GREQ};
  assign cmd_len = (state inside {S_GREQ, S_GWAIT}) ? chunk : '0;
  assign src_pop = eng_pull && state == S_GWAIT;
  always_comb begin
    if (state inside {S_GREQ, S_GWAIT})      cmd_hdr = {8'h02, addr};
    else if (state inside {S_WREQ, S_WWAIT}) cmd_hdr = {8'h06, {AW{1'b0}}};
    else                                     cmd_hdr = {8'h05, {AW{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; addr <= '0; rem <= '0; tmr <= '0; rdy <= '0;
      bytes_written <= '0; err <= E_OK; done <= 1'b0;
    end else begin
      done <= 1'b0;
      tmr  <= tmr + 1'b1;
      if (in_poll) rdy <= rdy + 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          bytes_written <= '0; err <= E_OK; addr <= req_addr; rem <= req_len;
          tmr <= '0; rdy <= '0;
          if (too_far) begin err <= E_RANGE; done <= 1'b1; end
          else if (req_len == '0) done <= 1'b1;
          else state <= S_PREQ;
        end
        S_PREQ, S_WREQ, S_GREQ: begin
          if (cmd_ack) begin
            tmr <= '0;
            state <= (state == S_PREQ) ? S_PWAIT : (state == S_WREQ) ? S_WWAIT : S_GWAIT;
          end else if (tmr >= cmd_tmo) begin
            state <= S_IDLE; err <= E_IO; done <= 1'b1;
          end
        end
        S_PWAIT: begin
          if (cmd_done) begin tmr <= '0; state <= cmd_wip ? S_PGAP : S_WREQ; end
          else if (tmr >= cmd_tmo) begin state <= S_IDLE; err <= E_IO; done <= 1'b1; end
        end
        S_PGAP: begin
          tmr <= '0;
          if (rdy >= ready_tmo) begin state <= S_IDLE; err <= E_BUSY; done <= 1'b1; end
          else state <= S_PREQ;
        end
        S_WWAIT: begin
          tmr <= '0;
          if (cmd_done) begin
            if (cmd_wm) state <= S_GREQ;
            else begin state <= S_IDLE; err <= E_IO; done <= 1'b1; end
          end else if (tmr >= cmd_tmo) begin state <= S_IDLE; err <= E_IO; done <= 1'b1; end
          else tmr <= tmr + 1'b1;
        end
        S_GWAIT: begin
          if (cmd_done) begin
            tmr <= '0; rdy <= '0;
            bytes_written <= bytes_written + LW'(chunk);
            addr <= addr + AW'(chunk);
            rem  <= rem - LW'(chunk);
            if (rem == LW'(chunk)) begin state <= S_IDLE; done <= 1'b1; end
            else state <= S_PREQ;
          end else if (tmr >= cmd_tmo) begin state <= S_IDLE; err <= E_IO; done <= 1'b1; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack && (tmr < cmd_tmo) |=> cmd_req && $stable(cmd_hdr) && $stable(cmd_len));
  p_page_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_hdr[AW+7:AW] == 8'h02 |->
      (cmd_len != '0) && (({1'b0, cmd_hdr[PW-1:0] & (page_size - 1'b1)} + {1'b0, cmd_len}) <= {1'b0, page_size}));
  p_poll_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PWAIT && cmd_done && cmd_wip |=> !cmd_req);
  p_pop_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> !cmd_req && cmd_hdr[AW+7:AW] == 8'h02);
  p_count_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bytes_written >= $past(bytes_written));
  p_range_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && err == E_RANGE |-> bytes_written == '0);
endmodule

// File: tb/test_flash_page_writer.sv
module test_flash_page_writer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [8:0]  page_size = 9'd16;
  logic [24:0] dev_size = 25'h100_0000;
  logic [19:0] ready_tmo = 20'd5000, cmd_tmo = 20'd20;
  logic cmd_req, cmd_ack = 1'b0, cmd_done = 1'b0, cmd_wip = 1'b0, cmd_wm = 1'b0;
  logic eng_pull = 1'b1, src_pop, busy, done;
  logic [31:0] cmd_hdr;
  logic [8:0]  cmd_len;
  logic [15:0] bytes_written;
  logic [1:0]  err;

  int tests = 0, fails = 0, cmds = 0;
  int busy_polls = 0, busy_left = 0, drop_pg = -1, fail_we = -1, pg_idx = 0, we_idx = 0;
  bit no_ack = 0, loose = 0;
  logic [40:0] exp_q[$];
  logic [40:0] got, want;

  always #2 clk = ~clk;

  flash_page_writer i_flash_page_writer (
    .clk, .rst_n, .req_valid, .req_addr, .req_len, .page_size, .dev_size,
    .ready_tmo, .cmd_tmo, .cmd_req, .cmd_hdr, .cmd_len, .cmd_ack, .cmd_done,
    .cmd_wip, .cmd_wm, .eng_pull, .src_pop, .busy, .done, .bytes_written, .err);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / engine model: pops expected commands and compares
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_req && !no_ack) begin
        got = {cmd_hdr, cmd_len};
        cmds++;
        if (!loose) begin
          if (exp_q.size() == 0) chk(0, "R1 R2 R3 R4 R5 unexpected command", got, 0);
          else begin
            want = exp_q.pop_front();
            chk(got == want, "R1 R2 R3 R4 R5 command sequence", got, want);
          end
        end
        if (cmd_hdr[31:24] == 8'h02) chk(src_pop == 1'b0, "R5 no pop before ack", src_pop, 0);
        cmd_ack = 1'b1;
        @(negedge clk); cmd_ack = 1'b0;
        repeat (2) @(negedge clk);
        if (got[40:33] == 8'h02 && pg_idx == drop_pg) begin
          pg_idx++;
          continue;
        end
        cmd_wip = 1'b0; cmd_wm = 1'b0;
        if (got[40:33] == 8'h05) begin
          if (busy_left > 0) begin cmd_wip = 1'b1; busy_left--; end
        end else if (got[40:33] == 8'h06) begin
          cmd_wm = (we_idx != fail_we);
          we_idx++;
        end else begin
          chk(src_pop == 1'b1, "R5 pop while programming", src_pop, 1);
          pg_idx++;
          busy_left = busy_polls;
        end
        cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        if (got[40:33] == 8'h05 && cmd_wip) chk(cmd_req == 1'b0, "R3 idle cycle between polls", cmd_req, 0);
        cmd_wip = 1'b0; cmd_wm = 1'b0;
      end
    end
  end

  // driver: builds the expected command list, runs one request, checks the result
  task automatic run(input logic [23:0] a, input int n, input int ps, input int bp,
                     input int dropg, input int failwe, input logic [1:0] e_err,
                     input int e_bytes, input string tag, input bit poke);
    int rem = n, k = 0, c0;
    logic [23:0] cur = a;
    busy_polls = bp; busy_left = bp; drop_pg = dropg; fail_we = failwe;
    pg_idx = 0; we_idx = 0;
    exp_q.delete();
    if (e_err != 2'd1 && !loose && !no_ack) begin
      while (rem > 0) begin
        int room = ps - (int'(cur) % ps);
        int c = (room < rem) ? room : rem;
        repeat (bp + 1) exp_q.push_back({8'h05, 24'h0, 9'd0});
        exp_q.push_back({8'h06, 24'h0, 9'd0});
        if (k == failwe) break;
        exp_q.push_back({8'h02, cur, 9'(c)});
        if (k == dropg) break;
        cur = cur + 24'(c); rem -= c; k++;
      end
    end
    c0 = cmds;
    @(negedge clk);
    req_addr = a; req_len = 16'(n); page_size = 9'(ps); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_addr = 24'h0; req_len = 16'd5; req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(err == e_err, {tag, " error code"}, err, e_err);
    chk(bytes_written == 16'(e_bytes), {tag, " bytes written"}, bytes_written, e_bytes);
    if (!loose && !no_ack) chk(exp_q.size() == 0, {tag, " all commands issued"}, exp_q.size(), 0);
    if (e_err == 2'd1 || n == 0) chk(cmds == c0, {tag, " no flash traffic"}, cmds - c0, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R12 reset busy", busy, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(cmd_req == 1'b0, "R11 reset cmd_req", cmd_req, 0);
    chk(src_pop == 1'b0, "R5 reset src_pop", src_pop, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2: head 11, full 16, tail 13
    run(24'h000105, 40, 16, 0, -1, -1, 2'd0, 40, "R1 R2 unaligned split", 0);
    // R2: aligned full pages of 64 and a single 256 page
    run(24'h000200, 64, 64, 0, -1, -1, 2'd0, 64, "R2 aligned page", 0);
    run(24'h000300, 256, 256, 1, -1, -1, 2'd0, 256, "R2 max page", 0);
    // R3: inside one page, two busy answers before ready
    run(24'h000010, 3, 256, 2, -1, -1, 2'd0, 3, "R3 repeated poll", 0);
    // R12: second request offered while running is ignored; chunks 1,32,32,5
    run(24'h003F1F, 70, 32, 1, -1, -1, 2'd0, 70, "R12 busy ignore", 1);
    // R6: range reject and exact-end acceptance
    dev_size = 25'h10000;
    run(24'h00FFF0, 17, 16, 0, -1, -1, 2'd1, 0, "R6 past end", 0);
    run(24'h00FFF0, 16, 16, 0, -1, -1, 2'd0, 16, "R6 exact end", 0);
    dev_size = 25'h100_0000;
    // R7: zero length
    run(24'h000040, 0, 16, 0, -1, -1, 2'd0, 0, "R7 zero length", 0);
    // R4 R8: write-enable refused on second chunk
    run(24'h000000, 40, 16, 0, -1, 1, 2'd2, 16, "R4 R8 write enable refused", 0);
    // R10 R8: third program never completes; chunks 8,16,16
    run(24'h000008, 40, 16, 0, 2, -1, 2'd2, 24, "R10 R8 missing completion", 0);
    // R9: flash stays busy
    loose = 1; ready_tmo = 20'd60;
    run(24'h000000, 8, 16, 100000, -1, -1, 2'd3, 0, "R9 ready timeout", 0);
    loose = 0; ready_tmo = 20'd5000;
    // R10: engine never acknowledges
    no_ack = 1;
    run(24'h000000, 8, 16, 0, -1, -1, 2'd2, 0, "R10 no acknowledge", 0);
    no_ack = 0;
    // R1 after error paths: normal operation resumes
    run(24'h0000F7, 20, 16, 0, -1, -1, 2'd0, 20, "R1 recovery", 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule